// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM and keeps its contents alive. It issues CAS-before-RAS refresh cycles, so it supplies no row address: the device steps its own internal row counter. Refresh can be spread evenly, with one cycle per row interval, or gathered into bursts that cover every row once per refresh period. The row interval comes from a clock-frequency parameter and a refresh-period parameter, divided by the row count that the density input selects.

A sleep request puts the device into its low-power self-refresh state. The block starts a CAS-before-RAS cycle and keeps both strobes low for at least the minimum self-refresh hold time. A wake request then raises both strobes and keeps them high for the exit recovery time. In burst mode, the block then runs a catch-up burst over every row before it signals that normal access may resume. In distributed mode, no catch-up burst is needed after exit.

`sleep_req` and `wake_req` are single-cycle pulses. Each is latched until the sequence can act on it. `mode_4k` and `burst` are static settings, changed only while reset is held.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `ras_n` and `cas_n` are 1, `busy` is 0 and `ready` is 1.
- R2: In every refresh cycle, `cas_n` falls `T_CSR` cycles before `ras_n` falls. `ras_n` then stays low for exactly `T_RAS` cycles, and both strobes rise in the same cycle. Both strobes stay high for at least `T_RP` cycles before `cas_n` falls again.
- R3: With `burst`=0, a refresh cycle starts once every row interval. The interval is the refresh period in cycles, (`CLK_KHZ`*`PERIOD_US`/1000), divided by the row count. The row count is 2*`ROWS_2K` when `mode_4k`=1 and `ROWS_2K` when `mode_4k`=0.
- R4: With `burst`=1, after every row-count intervals the block runs one refresh cycle per row, back to back. Successive `cas_n` falls in a burst are `T_CSR`+`T_RAS`+`T_RP`+1 cycles apart.
- R5: A `sleep_req` pulse makes `cas_n` fall and, `T_CSR` cycles later, `ras_n` fall. Both then stay low for at least `T_RASS` cycles. A `wake_req` that arrives before `T_RASS` has elapsed is held and acted on exactly when `T_RASS` is reached.
- R6: On exit from self-refresh, `ras_n` and `cas_n` rise together. Both then stay high for at least `T_RPS` cycles before any further strobe.
- R7: With `burst`=0, `ready` returns to 1 exactly `T_RPS` cycles after the exit rise, with no catch-up burst. The next refresh follows one row interval after that.
- R8: With `burst`=1, the exit is followed by one refresh cycle per row, back to back. `ready` stays 0 until the last of these cycles has finished its precharge.
- R9: `ready` is 0 from the cycle after `sleep_req` until the exit sequence ends. `busy` is 1 whenever either strobe is low and during every self-refresh phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_4k | input | 1 | Density select: 1 = twice `ROWS_2K` rows, 0 = `ROWS_2K` rows |
| burst | input | 1 | 1 = burst refresh, 0 = distributed refresh |
| sleep_req | input | 1 | Pulse: enter self-refresh |
| wake_req | input | 1 | Pulse: leave self-refresh |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| busy | output | 1 | A refresh or self-refresh sequence is in progress |
| ready | output | 1 | Normal accesses may be issued |

## Verification
The bench runs refresh in four patterns: distributed at both densities, burst at the higher density, and a self-refresh round trip in each refresh style. In the distributed runs, the spacing of `cas_n` falls is 40 or 80 cycles, depending on density. The burst run shows whether the rows are gathered into a back-to-back group and then repeated one period later. The two self-refresh runs use an early wake and a late wake, so the held-wake rule is kept apart from the late-wake case. They also show when `ready` returns and whether a catch-up burst follows the exit.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CAS, SQ_BOTH, SQ_PRE} strobe_ph_t;
  typedef enum logic [1:0] {SR_OFF, SR_CAS, SR_LOW, SR_EXIT} sr_st_t;
endpackage

// File: rtl/dref_tick.sv
module dref_tick #(
  parameter int INT_2K = 80,
  parameter int INT_4K = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mode_4k,
  output logic tick
);
  localparam int TW = $clog2(INT_2K + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;

  assign lim  = mode_4k ? TW'(INT_4K - 1) : TW'(INT_2K - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dref_ledger.sv
module dref_ledger #(
  parameter int ROWS_2K = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic burst,
  input  logic mode_4k,
  input  logic tick,
  input  logic take,
  input  logic load_rows,
  output logic owed_nz
);
  localparam int ROWS_4K = 2 * ROWS_2K;
  localparam int OW      = $clog2(2 * ROWS_4K + 1);

  logic [OW-1:0] rows, owed, tally, add_v;

  assign rows    = mode_4k ? OW'(ROWS_4K) : OW'(ROWS_2K);
  assign owed_nz = (owed != '0);

  always_comb begin
    add_v = '0;
    if (tick) begin
      if (!burst) add_v = OW'(1);
      else if (tally == rows - 1'b1) add_v = rows;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      owed  <= '0;
      tally <= '0;
    end else begin
      if (load_rows) owed <= rows;
      else owed <= owed + add_v - OW'(take);
      if (!burst) tally <= '0;
      else if (tick) tally <= (tally == rows - 1'b1) ? '0 : tally + 1'b1;
    end
  end
endmodule

// File: rtl/dref_strobe.sv
module dref_strobe
  import dref_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic ras_n,
  output logic cas_n
);
  localparam int CW = $clog2(T_CSR + T_RAS + T_RP + 1);

  strobe_ph_t    ph;
  logic [CW-1:0] cnt;

  assign idle  = (ph == SQ_IDLE);
  assign ras_n = (ph != SQ_BOTH);
  assign cas_n = !(ph == SQ_CAS || ph == SQ_BOTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        SQ_IDLE: if (start) begin ph <= SQ_CAS; cnt <= CW'(T_CSR - 1); end
        SQ_CAS:  if (cnt == '0) begin ph <= SQ_BOTH; cnt <= CW'(T_RAS - 1); end
                 else cnt <= cnt - 1'b1;
        SQ_BOTH: if (cnt == '0) begin ph <= SQ_PRE; cnt <= CW'(T_RP - 1); end
                 else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= SQ_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int CLK_KHZ   = 250000,
  parameter int PERIOD_US = 128000,
  parameter int ROWS_2K   = 2048,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 4,
  parameter int T_RASS    = 25000,
  parameter int T_RPS     = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_4k,
  input  logic burst,
  input  logic sleep_req,
  input  logic wake_req,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic ready
);
  localparam longint unsigned PERIOD_CYC =
    longint'(CLK_KHZ) * longint'(PERIOD_US) / 64'd1000;
  localparam int INT_2K = int'(PERIOD_CYC / longint'(ROWS_2K));
  localparam int INT_4K = int'(PERIOD_CYC / longint'(2 * ROWS_2K));
  localparam int SMAX_A = (T_RASS > T_RPS) ? T_RASS : T_RPS;
  localparam int SMAX   = (SMAX_A > T_CSR) ? SMAX_A : T_CSR;
  localparam int SW     = $clog2(SMAX + 1);

  sr_st_t        sr_st;
  logic [SW-1:0] sr_cnt;
  logic          sleep_pend, wake_pend, catching;
  logic          tick, owed_nz, start, go_sleep, exit_done, strobe_idle;
  logic          q_ras_n, q_cas_n;

  assign start     = (sr_st == SR_OFF) && strobe_idle && !sleep_pend && owed_nz;
  assign go_sleep  = (sr_st == SR_OFF) && strobe_idle && sleep_pend;
  assign exit_done = (sr_st == SR_EXIT) && (sr_cnt == '0);

  dref_tick #(.INT_2K(INT_2K), .INT_4K(INT_4K)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(sr_st == SR_OFF), .mode_4k(mode_4k), .tick(tick)
  );

  dref_ledger #(.ROWS_2K(ROWS_2K)) u_ledger (
    .clk(clk), .rst_n(rst_n), .clear(go_sleep), .burst(burst), .mode_4k(mode_4k),
    .tick(tick), .take(start), .load_rows(exit_done && burst), .owed_nz(owed_nz)
  );

  dref_strobe #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(strobe_idle),
    .ras_n(q_ras_n), .cas_n(q_cas_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_st      <= SR_OFF;
      sr_cnt     <= '0;
      sleep_pend <= 1'b0;
      wake_pend  <= 1'b0;
      catching   <= 1'b0;
    end else begin
      if (go_sleep) sleep_pend <= 1'b0;
      else if (sleep_req && sr_st == SR_OFF) sleep_pend <= 1'b1;

      if (sr_st == SR_OFF || sr_st == SR_EXIT) wake_pend <= 1'b0;
      else if (wake_req) wake_pend <= 1'b1;

      if (exit_done && burst) catching <= 1'b1;
      else if (catching && !owed_nz && strobe_idle && sr_st == SR_OFF) catching <= 1'b0;

      case (sr_st)
        SR_OFF:  if (go_sleep) begin sr_st <= SR_CAS; sr_cnt <= SW'(T_CSR - 1); end
        SR_CAS:  if (sr_cnt == '0) begin sr_st <= SR_LOW; sr_cnt <= SW'(T_RASS - 1); end
                 else sr_cnt <= sr_cnt - 1'b1;
        SR_LOW:  if (sr_cnt != '0) sr_cnt <= sr_cnt - 1'b1;
                 else if (wake_pend || wake_req) begin
                   sr_st  <= SR_EXIT;
                   sr_cnt <= SW'(T_RPS - 1);
                 end
        default: if (sr_cnt == '0) sr_st <= SR_OFF;
                 else sr_cnt <= sr_cnt - 1'b1;
      endcase
    end
  end

  always_comb begin
    case (sr_st)
      SR_CAS:  begin ras_n = 1'b1; cas_n = 1'b0; end
      SR_LOW:  begin ras_n = 1'b0; cas_n = 1'b0; end
      SR_EXIT: begin ras_n = 1'b1; cas_n = 1'b1; end
      default: begin ras_n = q_ras_n; cas_n = q_cas_n; end
    endcase
  end

  assign busy  = (sr_st != SR_OFF) || !strobe_idle;
  assign ready = (sr_st == SR_OFF) && !sleep_pend && !catching;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int T_RAS = 6,
  parameter int T_RP  = 4,
  parameter int T_RPS = 28
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic busy,
  input logic ready,
  input logic sleep_req
);
  localparam int MINHI = (T_RP < T_RPS) ? T_RP : T_RPS;

  logic [15:0] hi_run, lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= 16'hFFFF;
      lo_run <= '0;
    end else begin
      if (ras_n && cas_n) hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1;
      else hi_run <= '0;
      if (!ras_n) lo_run <= (lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1;
      else lo_run <= '0;
    end
  end

  assert_ras_under_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_cas_leads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  assert_precharge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (hi_run >= 16'(MINHI)));
  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_run >= 16'(T_RAS)));
  assert_rise_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));
  assert_busy_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> busy);
  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !ready);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .T_RAS(T_RAS), .T_RP(T_RP), .T_RPS(T_RPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .busy(busy), .ready(ready), .sleep_req(sleep_req)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int T_CSR = 2, T_RAS = 4, T_RP = 3, T_RASS = 10, T_RPS = 6;
  localparam int STEP  = T_CSR + T_RAS + T_RP + 1;

  logic clk = 1'b0, rst_n = 1'b0, mode_4k = 1'b1, burst = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic ras_n, cas_n, busy, ready;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .CLK_KHZ(1000), .PERIOD_US(640), .ROWS_2K(8),
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode_4k(mode_4k), .burst(burst),
    .sleep_req(sleep_req), .wake_req(wake_req),
    .ras_n(ras_n), .cas_n(cas_n), .busy(busy), .ready(ready)
  );

  typedef struct {
    int    lead;
    int    wmin;
    int    wmax;
    int    gap;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, rec_cnt = 0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(int lead, int wmin, int wmax, int gap, string tag);
    exp_t e;
    e.lead = lead; e.wmin = wmin; e.wmax = wmax; e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: measures each strobe cycle and compares with the scoreboard
  int  cyc = 0, t_cf = 0, t_rf = 0, last_cf = -1;
  logic p_ras = 1'b1, p_cas = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_cf = -1; p_ras = 1'b1; p_cas = 1'b1;
    end else begin
      if (p_cas && !cas_n) t_cf = cyc;
      if (p_ras && !ras_n) t_rf = cyc;
      if (!p_ras && ras_n) begin
        int lead, width, gap;
        lead  = t_rf - t_cf;
        width = cyc - t_rf;
        gap   = (last_cf < 0) ? -1 : t_cf - last_cf;
        last_cf = t_cf;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected strobe cycle", width, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(lead == e.lead, {e.tag, " cas lead"}, lead, e.lead);
          chk(width >= e.wmin && width <= e.wmax, {e.tag, " ras width"}, width, e.wmin);
          if (e.gap >= 0) chk(gap == e.gap, {e.tag, " spacing"}, gap, e.gap);
        end
        rec_cnt++;
      end
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  task automatic do_reset(bit m4k, bit bm);
    @(negedge clk);
    rst_n = 1'b0; mode_4k = m4k; burst = bm;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_recs(int n);
    while (rec_cnt < n) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
  endtask

  initial begin
    int base;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes in reset", {ras_n, cas_n}, 3);
    chk(!busy && ready, "R1 busy/ready in reset", {busy, ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !busy && ready, "R1 after release", {ras_n, cas_n, busy, ready}, 13);

    // R2 R3: distributed, higher density, interval 40
    do_reset(1'b1, 1'b0);
    base = rec_cnt;
    push(T_CSR, T_RAS, T_RAS, -1, "R2");
    for (int i = 0; i < 3; i++) push(T_CSR, T_RAS, T_RAS, 40, "R3 4k");
    wait_recs(base + 4);

    // R3: distributed, lower density, interval 80
    do_reset(1'b0, 1'b0);
    base = rec_cnt;
    push(T_CSR, T_RAS, T_RAS, -1, "R3 2k");
    for (int i = 0; i < 2; i++) push(T_CSR, T_RAS, T_RAS, 80, "R3 2k");
    wait_recs(base + 3);

    // R4: burst of 16 rows, next burst one period later
    do_reset(1'b1, 1'b1);
    base = rec_cnt;
    push(T_CSR, T_RAS, T_RAS, -1, "R4");
    for (int i = 0; i < 15; i++) push(T_CSR, T_RAS, T_RAS, STEP, "R4 burst");
    push(T_CSR, T_RAS, T_RAS, 640 - 15 * STEP, "R4 period");
    wait_recs(base + 17);

    // R5 R6 R7 R9: self-refresh, distributed, early wake
    do_reset(1'b1, 1'b0);
    base = rec_cnt;
    push(T_CSR, T_RAS, T_RAS, -1, "R2");
    push(T_CSR, T_RASS, T_RASS, -1, "R5 early wake held");
    push(T_CSR, T_RAS, T_RAS, T_CSR + T_RASS + T_RPS + 41, "R7 no catch-up");
    wait_recs(base + 1);
    pulse_sleep();
    chk(!ready, "R9 ready after sleep", ready, 0);
    while (ras_n) @(negedge clk);
    @(negedge clk);
    pulse_wake();
    chk(busy && !ras_n && !cas_n, "R9 busy in self-refresh", {busy, ras_n, cas_n}, 4);
    while (!ras_n) @(negedge clk);
    chk(cas_n, "R6 rise together", cas_n, 1);
    repeat (5) @(negedge clk);
    chk(ras_n && cas_n && !ready, "R6 exit hold", {ras_n, cas_n, ready}, 6);
    @(negedge clk);
    chk(ready, "R7 ready after exit", ready, 1);
    wait_recs(base + 3);

    // R5 R8: self-refresh, burst, late wake, catch-up burst
    do_reset(1'b1, 1'b1);
    base = rec_cnt;
    push(T_CSR, T_RASS, 40, -1, "R5 late wake");
    push(T_CSR, T_RAS, T_RAS, T_CSR + 0, "R8");
    exp_q[1].gap = -1;
    for (int i = 0; i < 15; i++) push(T_CSR, T_RAS, T_RAS, STEP, "R8 catch-up");
    @(negedge clk);
    pulse_sleep();
    while (ras_n) @(negedge clk);
    repeat (20) @(negedge clk);
    pulse_wake();
    while (!ras_n) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(!ready, "R8 ready during catch-up", ready, 0);
    wait_recs(base + 9);
    chk(!ready, "R8 ready mid catch-up", ready, 0);
    wait_recs(base + 17);
    chk(!ready, "R8 ready at last row", ready, 0);
    repeat (4) @(negedge clk);
    chk(ready, "R8 ready after catch-up", ready, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule